// File: doc/BRIEF.md
# Iterative DES Block Cipher Engine

This block encrypts or decrypts one 64-bit block under a 64-bit key. It runs one Feistel round per clock, so a block takes sixteen rounds in sixteen consecutive cycles after it is taken in. A source hands a block over with a valid/accept handshake. The mode bit, key and data are captured together at that edge. The result is then offered to a sink through a second valid/accept pair, which the sink can stall for as long as it needs.

Only one block is in flight at a time. The engine stops accepting input once a block is taken, and starts again only after the sink has taken the result. Decryption walks the same key schedule in reverse: the subkeys come out last-first and the half-key registers rotate right. A transaction chooses its direction by its own mode bit, so encrypt and decrypt blocks can alternate freely.

Top module: `des_iter_core`

## Requirements
- R1: With `in_mode`=0 the engine encrypts (standard DES). Vector bit 63 is cipher bit 1, the leftmost bit. Key 0101010101010101 with plaintext 8000000000000000 gives 95F8A5E5DD31D900, and key 133457799BBCDFF1 with plaintext 0123456789ABCDEF gives 85E813540F0AB405.
- R2: With `in_mode`=1 the engine decrypts. Under key 0101010101010101, the ciphertexts of a single 1 walked right from 8000000000000000 decrypt back to that walking plaintext.
- R3: A block is taken only on a rising edge where `in_valid` and `in_accept` are both 1. `in_accept` is low from that edge until the result has been handed off, and is never high while `out_valid` is high. A source that holds `in_valid` during that time is not taken early.
- R4: `out_valid` rises on the 16th rising edge after the accepting edge.
- R5: While `out_valid`=1 and `out_accept`=0, `out_valid` and `out_data` hold. On the edge where both are 1, `out_valid` drops and `in_accept` returns.
- R6: The least significant bit of every key byte (vector bits 0, 8, ..., 56) does not affect the result.
- R7: A key with a single 1 at any of the 56 non-parity positions, with plaintext 0, gives 56 distinct ciphertexts.
- R8: Mode, key and data are registered at acceptance. Changes on those inputs while a block is in flight do not alter its result.
- R9: While `rst_n`=0 the engine is idle, with `in_accept`=1 and `out_valid`=0. A valid input during reset is not taken.
- R10: The direction is chosen per block, so back-to-back blocks of alternating mode each give the correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_mode | input | 1 | 0 = encrypt, 1 = decrypt |
| in_key | input | 64 | Key including the byte parity bits |
| in_data | input | 64 | Plaintext or ciphertext block |
| in_valid | input | 1 | Source offers a block |
| in_accept | output | 1 | Engine can take a block this cycle |
| out_data | output | 64 | Result block |
| out_valid | output | 1 | Result is presented |
| out_accept | input | 1 | Sink takes the result this cycle |

## Verification
The hardest situation to create from the ports is a second block arriving while the first is still running. The second block must wait, and its input values must have no effect on the first result. The bench reaches this state by accepting one block and then, during the sixteen busy cycles, changing key, data and mode at random. It then asserts `in_valid` with a second, known vector and holds it across the stalled result handoff. This shows that the first result is unchanged and that the waiting block is taken only on the edge after the handoff. It also checks that the waiting block produces its own known answer.

// File: rtl/des_iter_pkg.sv
package des_iter_pkg;

    localparam int BLK_W      = 64;
    localparam int HALF_W     = BLK_W / 2;
    localparam int PC_W       = 56;
    localparam int CD_W       = PC_W / 2;
    localparam int SUB_W      = 48;
    localparam int SIN_W      = 6;
    localparam int SOUT_W     = 4;
    localparam int SBOX_N     = SUB_W / SIN_W;
    localparam int SBOX_ENT   = 1 << SIN_W;
    localparam int SBOX_BITS  = SBOX_ENT * SOUT_W;
    localparam int NUM_ROUNDS = 16;
    localparam int RND_W      = $clog2(NUM_ROUNDS);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [RND_W-1:0]    rnd;
        logic                dec;
        logic [HALF_W-1:0]   lh;
        logic [HALF_W-1:0]   rh;
        logic [CD_W-1:0]     c;
        logic [CD_W-1:0]     d;
        logic [BLK_W-1:0]    res;
    } core_state_t;

    // Source positions are 1-based, counted from the leftmost bit.
    localparam int PC1_TBL [PC_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };

    localparam int PC2_TBL [SUB_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    localparam int P_TBL [HALF_W] = '{
        16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
         2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25
    };

    // Each word: 64 nibbles, entry 0 in the top nibble, entry = row*16+col.
    localparam logic [SBOX_BITS-1:0] SBOX_TBL [SBOX_N] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    function automatic logic [BLK_W-1:0] ip_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] o;
        int row, col, src;
        o = '0;
        for (int k = 0; k < BLK_W; k++) begin
            row = k / 8;
            col = k % 8;
            src = (row < 4) ? (58 + 2 * row - 8 * col) : (57 + 2 * (row - 4) - 8 * col);
            o[BLK_W-1-k] = x[BLK_W-src];
        end
        return o;
    endfunction

    function automatic logic [BLK_W-1:0] fp_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] o;
        int row, col, src;
        o = '0;
        for (int k = 0; k < BLK_W; k++) begin
            row = k / 8;
            col = k % 8;
            src = ((col % 2 == 0) ? (40 + 8 * (col / 2)) : (8 + 8 * (col / 2))) - row;
            o[BLK_W-1-k] = x[BLK_W-src];
        end
        return o;
    endfunction

    function automatic logic [SUB_W-1:0] e_expand(input logic [HALF_W-1:0] x);
        logic [SUB_W-1:0] o;
        int row, col, src;
        o = '0;
        for (int k = 0; k < SUB_W; k++) begin
            row = k / SIN_W;
            col = k % SIN_W;
            src = ((4 * row + col + HALF_W - 1) % HALF_W) + 1;
            o[SUB_W-1-k] = x[HALF_W-src];
        end
        return o;
    endfunction

    function automatic logic [HALF_W-1:0] p_perm(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] o;
        o = '0;
        for (int k = 0; k < HALF_W; k++) o[HALF_W-1-k] = x[HALF_W-P_TBL[k]];
        return o;
    endfunction

    function automatic logic [PC_W-1:0] pc1_perm(input logic [BLK_W-1:0] x);
        logic [PC_W-1:0] o;
        o = '0;
        for (int k = 0; k < PC_W; k++) o[PC_W-1-k] = x[BLK_W-PC1_TBL[k]];
        return o;
    endfunction

    function automatic logic [SUB_W-1:0] pc2_perm(input logic [PC_W-1:0] x);
        logic [SUB_W-1:0] o;
        o = '0;
        for (int k = 0; k < SUB_W; k++) o[SUB_W-1-k] = x[PC_W-PC2_TBL[k]];
        return o;
    endfunction

endpackage

// File: rtl/des_sbox.sv
module des_sbox
    import des_iter_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [SIN_W-1:0]  sel,
    output logic [SOUT_W-1:0] val
);
    localparam logic [SBOX_BITS-1:0] TBL = SBOX_TBL[IDX];

    logic [SIN_W-1:0] entry;
    int unsigned      pos;

    always_comb begin
        // outer bits pick the row, inner four bits pick the column
        entry = {sel[SIN_W-1], sel[0], sel[SIN_W-2:1]};
        pos   = (SBOX_ENT - 1 - int'(entry)) * SOUT_W;
        val   = TBL[pos +: SOUT_W];
    end
endmodule

// File: rtl/des_feistel.sv
module des_feistel
    import des_iter_pkg::*;
(
    input  logic [HALF_W-1:0] r_half,
    input  logic [SUB_W-1:0]  subkey,
    output logic [HALF_W-1:0] f_out
);
    logic [SUB_W-1:0]  mixed;
    logic [HALF_W-1:0] sub_out;

    assign mixed = e_expand(r_half) ^ subkey;

    for (genvar g = 0; g < SBOX_N; g++) begin : g_box
        des_sbox #(.IDX(g)) u_box (
            .sel (mixed[SUB_W-1-SIN_W*g -: SIN_W]),
            .val (sub_out[HALF_W-1-SOUT_W*g -: SOUT_W])
        );
    end

    assign f_out = p_perm(sub_out);
endmodule

// File: rtl/des_keystep.sv
module des_keystep
    import des_iter_pkg::*;
(
    input  logic [CD_W-1:0]  c_in,
    input  logic [CD_W-1:0]  d_in,
    input  logic [RND_W-1:0] rnd,
    input  logic             dec,
    output logic [CD_W-1:0]  c_nxt,
    output logic [CD_W-1:0]  d_nxt,
    output logic [SUB_W-1:0] subkey
);
    localparam logic [RND_W-1:0] RND_FIRST = RND_W'(0);
    localparam logic [RND_W-1:0] RND_SEC   = RND_W'(1);
    localparam logic [RND_W-1:0] RND_NINE  = RND_W'(8);
    localparam logic [RND_W-1:0] RND_LAST  = RND_W'(NUM_ROUNDS - 1);

    logic [1:0] amt;

    function automatic logic [CD_W-1:0] rot(input logic [CD_W-1:0] x,
                                            input logic [1:0] n,
                                            input logic right);
        logic [CD_W-1:0] o;
        case (n)
            2'd1:    o = right ? {x[0], x[CD_W-1:1]} : {x[CD_W-2:0], x[CD_W-1]};
            2'd2:    o = right ? {x[1:0], x[CD_W-1:2]} : {x[CD_W-3:0], x[CD_W-1:CD_W-2]};
            default: o = x;
        endcase
        return o;
    endfunction

    always_comb begin
        if (!dec) begin
            amt = (rnd == RND_FIRST || rnd == RND_SEC || rnd == RND_NINE || rnd == RND_LAST)
                  ? 2'd1 : 2'd2;
        end else if (rnd == RND_FIRST) begin
            amt = 2'd0;
        end else begin
            amt = (rnd == RND_SEC || rnd == RND_NINE || rnd == RND_LAST) ? 2'd1 : 2'd2;
        end
        c_nxt  = rot(c_in, amt, dec);
        d_nxt  = rot(d_in, amt, dec);
        subkey = pc2_perm({c_nxt, d_nxt});
    end
endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
    import des_iter_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_mode,
    input  logic [BLK_W-1:0] in_key,
    input  logic [BLK_W-1:0] in_data,
    input  logic             in_valid,
    output logic             in_accept,
    output logic [BLK_W-1:0] out_data,
    output logic             out_valid,
    input  logic             out_accept
);
    localparam logic [RND_W-1:0] RND_LAST = RND_W'(NUM_ROUNDS - 1);

    core_state_t cur_q, nxt_d;

    logic [BLK_W-1:0]  ip_w;
    logic [PC_W-1:0]   pc_w;
    logic [CD_W-1:0]   c_step, d_step;
    logic [SUB_W-1:0]  sk_w;
    logic [HALF_W-1:0] f_w;
    logic [HALF_W-1:0] r_new;

    assign ip_w = ip_perm(in_data);
    assign pc_w = pc1_perm(in_key);

    des_keystep u_key (
        .c_in   (cur_q.c),
        .d_in   (cur_q.d),
        .rnd    (cur_q.rnd),
        .dec    (cur_q.dec),
        .c_nxt  (c_step),
        .d_nxt  (d_step),
        .subkey (sk_w)
    );

    des_feistel u_f (
        .r_half (cur_q.rh),
        .subkey (sk_w),
        .f_out  (f_w)
    );

    assign r_new = cur_q.lh ^ f_w;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    nxt_d.lh    = ip_w[BLK_W-1:HALF_W];
                    nxt_d.rh    = ip_w[HALF_W-1:0];
                    nxt_d.c     = pc_w[PC_W-1:CD_W];
                    nxt_d.d     = pc_w[CD_W-1:0];
                    nxt_d.dec   = in_mode;
                    nxt_d.rnd   = '0;
                    nxt_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                nxt_d.c   = c_step;
                nxt_d.d   = d_step;
                nxt_d.lh  = cur_q.rh;
                nxt_d.rh  = r_new;
                nxt_d.rnd = cur_q.rnd + RND_W'(1);
                if (cur_q.rnd == RND_LAST) begin
                    // halves swapped ahead of the final permutation
                    nxt_d.res   = fp_perm({r_new, cur_q.rh});
                    nxt_d.phase = PH_DONE;
                end
            end
            PH_DONE: begin
                if (out_accept) nxt_d.phase = PH_IDLE;
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign in_accept = (cur_q.phase == PH_IDLE);
    assign out_valid = (cur_q.phase == PH_DONE);
    assign out_data  = cur_q.res;
endmodule

// File: rtl/des_iter_chk.sv
module des_iter_chk
    import des_iter_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_accept,
    input logic [BLK_W-1:0] out_data,
    input logic             out_valid,
    input logic             out_accept
);
    localparam int LAT_W = RND_W + 1;

    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else if (in_valid && in_accept) lat_q <= '0;
        else if (!out_valid && lat_q != LAT_W'(NUM_ROUNDS)) lat_q <= lat_q + LAT_W'(1);
    end

    // R3
    taken_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_accept) |=> !in_accept);

    // R3
    busy_stays_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_accept && !out_valid) |=> !in_accept);

    // R3
    no_accept_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_accept && out_valid));

    // R4
    round_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (lat_q == LAT_W'(NUM_ROUNDS)));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_accept) |=> (out_valid && $stable(out_data)));

    // R5
    result_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_accept) |=> (!out_valid && in_accept));
endmodule

bind des_iter_core des_iter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_accept  (in_accept),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_accept (out_accept)
);

// File: tb/tb_des_iter_core.sv
`timescale 1ns/1ps
module tb_des_iter_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_mode = 1'b0;
    logic [63:0] in_key = '0;
    logic [63:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_accept;
    logic [63:0] out_data;
    logic        out_valid;
    logic        out_accept = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;

    // behavioural handshake model: 0 idle, 1 running, 2 result held
    int mph  = 0;
    int mcnt = 0;

    localparam logic [63:0] K0   = 64'h0101010101010101;
    localparam logic [63:0] KC   = 64'h133457799BBCDFF1;
    localparam logic [63:0] PC   = 64'h0123456789ABCDEF;
    localparam logic [63:0] CC   = 64'h85E813540F0AB405;

    logic [63:0] kat [6] = '{64'h95F8A5E5DD31D900, 64'hDD7F121CA5015619,
                             64'h2E8653104F3834EA, 64'h4BD388FF6CD81D4F,
                             64'h20B9E767B2FB1456, 64'h55579380D77138EF};

    des_iter_core dut (
        .clk(clk), .rst_n(rst_n), .in_mode(in_mode), .in_key(in_key),
        .in_data(in_data), .in_valid(in_valid), .in_accept(in_accept),
        .out_data(out_data), .out_valid(out_valid), .out_accept(out_accept)
    );

    always #2 clk = ~clk;

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mph = 0;
        end else begin
            case (mph)
                0: if (in_valid) begin mph = 1; mcnt = 0; end
                1: begin mcnt++; if (mcnt == 16) mph = 2; end
                default: if (out_accept) mph = 0;
            endcase
        end
        if (cyc > 150000 && !ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    always @(negedge clk) begin
        chk(in_accept == (mph == 0), "R3 accept vs model", 64'(in_accept), 64'(mph == 0));
        chk(out_valid == (mph == 2), "R4 valid vs model", 64'(out_valid), 64'(mph == 2));
    end

    task automatic drive_in(input logic m, input logic [63:0] k, input logic [63:0] d);
        in_mode  = m;
        in_key   = k;
        in_data  = d;
        in_valid = 1'b1;
    endtask

    task automatic wait_take(output int acc_cyc);
        while (!in_accept) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        acc_cyc  = cyc;
        in_valid = 1'b0;
    endtask

    task automatic get_res(input int hold, output logic [63:0] got, output int vcyc);
        do @(negedge clk); while (!out_valid);
        vcyc = cyc;
        got  = out_data;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(out_valid && out_data == got, "R5 hold", out_data, got);
        end
        out_accept = 1'b1;
        @(negedge clk);
        out_accept = 1'b0;
    endtask

    task automatic xact(input logic m, input logic [63:0] k, input logic [63:0] d,
                        input int hold, output logic [63:0] got);
        int a, v;
        drive_in(m, k, d);
        wait_take(a);
        get_res(hold, got, v);
        chk(v - a == 16, "R4 latency", 64'(v - a), 64'd16);
    endtask

    initial begin
        logic [63:0] got, got2;
        logic [63:0] wct [56];
        int a, v, nk;

        // R9: reset idles the engine, valid input during reset ignored
        in_valid = 1'b1;
        in_data  = 64'hFFFF_0000_FFFF_0000;
        repeat (4) @(negedge clk);
        chk(in_accept == 1'b1, "R9 accept in reset", 64'(in_accept), 64'd1);
        chk(out_valid == 1'b0, "R9 valid in reset", 64'(out_valid), 64'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        repeat (2) @(negedge clk);
        chk(in_accept == 1'b1, "R9 accept after reset", 64'(in_accept), 64'd1);
        chk(out_valid == 1'b0, "R9 valid after reset", 64'(out_valid), 64'd0);

        // R1: encryption known answers
        for (int i = 0; i < 6; i++) begin
            xact(1'b0, K0, 64'h8000000000000000 >> i, 0, got);
            chk(got == kat[i], "R1 walking plaintext", got, kat[i]);
        end
        xact(1'b0, KC, PC, 0, got);
        chk(got == CC, "R1 classic vector", got, CC);

        // R2: decryption recovers the walking plaintext
        for (int i = 0; i < 6; i++) begin
            xact(1'b1, K0, kat[i], 0, got);
            chk(got == (64'h8000000000000000 >> i), "R2 walking decrypt", got, 64'h8000000000000000 >> i);
        end
        xact(1'b1, KC, CC, 0, got);
        chk(got == PC, "R2 classic decrypt", got, PC);

        // R6: flipping parity bits leaves the result unchanged
        xact(1'b0, 64'h0, 64'h8000000000000000, 0, got);
        chk(got == kat[0], "R6 zero-parity key", got, kat[0]);
        xact(1'b0, KC ^ K0, PC, 0, got);
        chk(got == CC, "R6 flipped parity", got, CC);
        xact(1'b1, 64'hFEFE_FEFE_FEFE_FEFE ^ 64'hFFFF_FFFF_FFFF_FFFF ^ K0, kat[1], 0, got);
        chk(got == 64'h4000000000000000, "R6 decrypt parity", got, 64'h4000000000000000);

        // R7: single-bit keys at non-parity positions give distinct results
        nk = 0;
        for (int i = 0; i < 64; i++) begin
            if (i % 8 != 7) begin
                bit dup;
                xact(1'b0, 64'h1 << (63 - i), 64'h0, 0, got);
                dup = 0;
                for (int j = 0; j < nk; j++) if (wct[j] == got) dup = 1;
                chk(!dup, "R7 distinct ciphertext", got, 64'h0);
                wct[nk] = got;
                nk++;
            end
        end

        // R8 + R3: inputs churn while busy, then a second block waits
        drive_in(1'b0, KC, PC);
        wait_take(a);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_mode = ~in_mode;
            in_key  = {$urandom, $urandom};
            in_data = {$urandom, $urandom};
        end
        drive_in(1'b1, K0, kat[0]);
        get_res(3, got, v);
        chk(got == CC, "R8 in-flight isolation", got, CC);
        chk(v - a == 16, "R4 latency under churn", 64'(v - a), 64'd16);
        chk(in_accept == 1'b1 && in_valid == 1'b1, "R3 waiting block pending", 64'(in_accept), 64'd1);
        wait_take(a);
        get_res(0, got2, v);
        chk(got2 == 64'h8000000000000000, "R3 waiting block result", got2, 64'h8000000000000000);

        // R5: long stall at the output
        xact(1'b0, K0, 64'h0800000000000000, 7, got);
        chk(got == kat[4], "R5 stalled result", got, kat[4]);

        // R10: alternating modes back to back
        for (int i = 0; i < 4; i++) begin
            xact(1'b0, K0, 64'h8000000000000000 >> (i + 2), 0, got);
            chk(got == kat[i + 2], "R10 encrypt leg", got, kat[i + 2]);
            xact(1'b1, KC, CC, 0, got);
            chk(got == PC, "R10 decrypt leg", got, PC);
        end

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule